// File: doc/BRIEF.md
# Modem Control and Status Register Pair with Loopback

This block holds the modem-side control and status state of a 16550-style serial port. A 5-bit control register drives the four handshake outputs (request-to-send, terminal-ready and the two general-purpose outputs) and a loopback enable. A status register tracks the levels of the four handshake inputs: clear-to-send, set-ready, ring and carrier detect. Beside each level it keeps a sticky change flag, so software can see that a line moved since its last look.

The external inputs pass through a synchronizer. Each level change then sets its change flag. The ring line flags only its falling (trailing) edge. A read of the status register returns the value and clears the change flags. An interrupt request stays high while any change flag is set. In loopback the status levels show the control outputs, crossed over. The external request-to-send and terminal-ready pins are held low, and external input activity sets no flags.

The register bus is simple. The read data always shows the selected register. A read strobe with the status select clears the change flags at the clock edge, and a write strobe loads the control register.

Top module: `modem_ctl_status`

## Requirements
- R1: After reset the control register reads 0x08 (only OUT2 set). The status register reads 0xB0: carrier (bit 7), set-ready (bit 5) and clear-to-send (bit 4) high, ring (bit 6) low, every change flag (bits 3..0) low. ms_irq is low.
- R2: A control write keeps only bits 4..0: bit 4 loopback, bit 3 OUT2, bit 2 OUT1, bit 1 RTS, bit 0 DTR. It takes effect at the clock edge. Reads return bits 7..5 as zero, and the outputs follow the stored bits when loopback is off.
- R3: A level change on carrier, set-ready or clear-to-send sets its change flag: bit 3, bit 1 and bit 0 respectively. The flag is the old level XOR the new level, ORed into the held flags. Several lines may change together.
- R4: The ring change flag (bit 2) is set only when ring goes from 1 to 0. A rising ring edge sets no flag.
- R5: A status read (bus_rd with bus_sel=1) returns the current value, then clears bits 3..0 and leaves the levels unchanged. A change that lands on the same edge as the clearing read survives it.
- R6: ms_irq is high exactly when at least one change flag is set.
- R7: An external input change shows in the status register on the third rising clock edge after it, not earlier.
- R8: With loopback on, the status levels read OUT2 in carrier, OUT1 in ring, DTR in set-ready and RTS in clear-to-send.
- R9: With loopback on, rts_o and dtr_o are held low. out1_o and out2_o still follow their bits.
- R10: With loopback on, neither external input changes nor changes in the looped levels set a change flag. On leaving loopback the status shows the current external levels, with no flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the control register |
| bus_rd | input | 1 | Read strobe; with bus_sel=1 it clears the change flags |
| bus_sel | input | 1 | Register select: 0 control, 1 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| cts_i | input | 1 | Clear-to-send line, asynchronous |
| dsr_i | input | 1 | Set-ready line, asynchronous |
| ri_i | input | 1 | Ring line, asynchronous |
| dcd_i | input | 1 | Carrier detect line, asynchronous |
| rts_o | output | 1 | Request-to-send output |
| dtr_o | output | 1 | Terminal-ready output |
| out1_o | output | 1 | General-purpose output 1 |
| out2_o | output | 1 | General-purpose output 2 |
| ms_irq | output | 1 | Modem status interrupt request |

## Verification
The assertions assume that bus_sel and the strobes are stable around the sampling edge. They also assume reset brings the synchronizer to the same levels the status register resets to, so the first compare after reset sees no change. The stimulus moves the inputs and strobes only at falling clock edges. It holds the modem lines at the reset levels (carrier, set-ready and clear-to-send high, ring low) while reset is applied. It also waits out the synchronizer before it reads, except in the one case that puts a level change on the same edge as a clearing read.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int MCR_W = 5;
  localparam int LVL_W = 4;
  // Level nibble order (matches status bits 7..4): {carrier, ring, set-ready, clear-to-send}
  localparam int L_DCD = 3;
  localparam int L_RI  = 2;
  localparam int L_DSR = 1;
  localparam int L_CTS = 0;
  // Control bit positions
  localparam int C_LOOP = 4;
  localparam int C_OUT2 = 3;
  localparam int C_OUT1 = 2;
  localparam int C_RTS  = 1;
  localparam int C_DTR  = 0;

  localparam logic [MCR_W-1:0] MCR_RST = 5'b01000;
  localparam logic [LVL_W-1:0] LVL_RST = 4'b1011;

  // Change flags produced by one level update; ring flags only a 1->0 move
  function automatic logic [LVL_W-1:0] change_flags(input logic [LVL_W-1:0] prev,
                                                    input logic [LVL_W-1:0] next);
    logic [LVL_W-1:0] diff;
    diff = prev ^ next;
    diff[L_RI] = diff[L_RI] & prev[L_RI] & ~next[L_RI];
    return diff;
  endfunction

  // Crossed mapping of control bits onto status levels in loopback
  function automatic logic [LVL_W-1:0] looped_levels(input logic [MCR_W-1:0] ctl);
    logic [LVL_W-1:0] l;
    l[L_DCD] = ctl[C_OUT2];
    l[L_RI]  = ctl[C_OUT1];
    l[L_DSR] = ctl[C_DTR];
    l[L_CTS] = ctl[C_RTS];
    return l;
  endfunction
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/modem_ctrl_reg.sv
module modem_ctrl_reg
  import modem_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [7:0]       wdata,
  output logic [MCR_W-1:0] ctl,
  output logic             rts_o,
  output logic             dtr_o,
  output logic             out1_o,
  output logic             out2_o
);
  logic [MCR_W-1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl_q <= MCR_RST;
    else if (wr) ctl_q <= wdata[MCR_W-1:0];
  end

  assign ctl    = ctl_q;
  assign rts_o  = ctl_q[C_RTS] & ~ctl_q[C_LOOP];
  assign dtr_o  = ctl_q[C_DTR] & ~ctl_q[C_LOOP];
  assign out1_o = ctl_q[C_OUT1];
  assign out2_o = ctl_q[C_OUT2];

  // R2
  wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ctl_q == $past(wdata[MCR_W-1:0]));
  // R9
  loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[C_LOOP] |-> (!rts_o && !dtr_o));
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import modem_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] ext_lvl,
  input  logic             loop_en,
  input  logic [LVL_W-1:0] loop_lvl,
  input  logic             clr,
  output logic [7:0]       status,
  output logic             any_change
);
  logic [LVL_W-1:0] lvl_q;
  logic [LVL_W-1:0] flag_q;
  logic [LVL_W-1:0] delta_set;
  logic [LVL_W-1:0] flag_next;

  // Named event: flags raised by this cycle's level update
  assign delta_set = loop_en ? '0 : change_flags(lvl_q, ext_lvl);
  assign flag_next = (clr ? '0 : flag_q) | delta_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= LVL_RST;
      flag_q <= '0;
    end else begin
      lvl_q  <= ext_lvl;
      flag_q <= flag_next;
    end
  end

  assign status     = {(loop_en ? loop_lvl : lvl_q), flag_q};
  assign any_change = |flag_q;

  // R4
  ring_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[L_RI]) |-> ($past(lvl_q[L_RI]) && !lvl_q[L_RI]));
  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((flag_q & ~$past(delta_set)) == '0));
  // R10
  loop_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && !clr) |=> $stable(flag_q));
  // R3
  level_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|delta_set) |=> (lvl_q != $past(lvl_q)));
endmodule

// File: rtl/modem_ctl_status.sv
module modem_ctl_status
  import modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       cts_i,
  input  logic       dsr_i,
  input  logic       ri_i,
  input  logic       dcd_i,
  output logic       rts_o,
  output logic       dtr_o,
  output logic       out1_o,
  output logic       out2_o,
  output logic       ms_irq
);
  logic [MCR_W-1:0] ctl;
  logic [LVL_W-1:0] raw_lvl;
  logic [LVL_W-1:0] sync_lvl;
  logic [7:0]       status;
  logic             status_clr;

  assign raw_lvl    = {dcd_i, ri_i, dsr_i, cts_i};
  assign status_clr = bus_rd & bus_sel;

  modem_sync #(.W(LVL_W), .STAGES(SYNC_STAGES), .RST_VAL(LVL_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_lvl), .q(sync_lvl)
  );

  modem_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .wdata(bus_wdata), .ctl(ctl),
    .rts_o(rts_o), .dtr_o(dtr_o), .out1_o(out1_o), .out2_o(out2_o)
  );

  modem_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .ext_lvl(sync_lvl), .loop_en(ctl[C_LOOP]),
    .loop_lvl(looped_levels(ctl)), .clr(status_clr), .status(status),
    .any_change(ms_irq)
  );

  assign bus_rdata = bus_sel ? status : {{(8-MCR_W){1'b0}}, ctl};

  // R8
  loop_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && ctl[C_LOOP]) |-> (bus_rdata[7] == out2_o && bus_rdata[6] == out1_o));
  // R10
  irq_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ms_irq) |-> !$past(ctl[C_LOOP]));
endmodule

// File: tb/modem_ctl_status_tb.sv
module modem_ctl_status_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic cts_i = 1'b1, dsr_i = 1'b1, ri_i = 1'b0, dcd_i = 1'b1;
  logic rts_o, dtr_o, out1_o, out2_o, ms_irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  modem_ctl_status u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cts_i(cts_i), .dsr_i(dsr_i),
    .ri_i(ri_i), .dcd_i(dcd_i), .rts_o(rts_o), .dtr_o(dtr_o), .out1_o(out1_o),
    .out2_o(out2_o), .ms_irq(ms_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(input logic sel, output logic [7:0] d);
    bus_sel = sel;
    #2 d = bus_rdata;
  endtask

  task automatic rd_reg(input logic sel, output logic [7:0] d);
    bus_sel = sel; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    peek(1'b0, d); chk("R1 ctl", d, 8'h08);
    peek(1'b1, d); chk("R1 status", d, 8'hB0);
    chk("R1 irq", {7'b0, ms_irq}, 8'h00);
    chk("R1 out2", {7'b0, out2_o}, 8'h01);
  endtask

  task automatic t_ctl();
    logic [7:0] d;
    wr_ctl(8'hE3);
    peek(1'b0, d); chk("R2 store", d, 8'h03);
    chk("R2 pins", {4'b0, out2_o, out1_o, rts_o, dtr_o}, 8'h03);
    wr_ctl(8'h0C);
    chk("R2 pins2", {4'b0, out2_o, out1_o, rts_o, dtr_o}, 8'h0C);
  endtask

  task automatic t_cts();
    logic [7:0] d;
    cts_i = 1'b0;
    tick(2);
    peek(1'b1, d); chk("R7 early", d, 8'hB0);
    tick(1);
    peek(1'b1, d); chk("R7 third edge", d, 8'hA1);
    chk("R6 irq set", {7'b0, ms_irq}, 8'h01);
    rd_reg(1'b1, d); chk("R5 read value", d, 8'hA1);
    peek(1'b1, d); chk("R5 cleared", d, 8'hA0);
    chk("R6 irq clear", {7'b0, ms_irq}, 8'h00);
  endtask

  task automatic t_ring();
    logic [7:0] d;
    ri_i = 1'b1;
    tick(3);
    peek(1'b1, d); chk("R4 rise no flag", d, 8'hE0);
    chk("R4 irq rise", {7'b0, ms_irq}, 8'h00);
    ri_i = 1'b0;
    tick(3);
    peek(1'b1, d); chk("R4 fall flag", d, 8'hA4);
    chk("R6 irq ring", {7'b0, ms_irq}, 8'h01);
    rd_reg(1'b1, d);
    peek(1'b1, d); chk("R5 ring clear", d, 8'hA0);
  endtask

  task automatic t_multi();
    logic [7:0] d;
    dcd_i = 1'b0; cts_i = 1'b1;
    tick(3);
    peek(1'b1, d); chk("R3 two lines", d, 8'h39);
    rd_reg(1'b1, d);
    peek(1'b1, d); chk("R5 multi clear", d, 8'h30);
  endtask

  task automatic t_race();
    logic [7:0] d;
    dsr_i = 1'b0;
    tick(2);
    rd_reg(1'b1, d); chk("R5 race read", d, 8'h30);
    peek(1'b1, d); chk("R5 race survives", d, 8'h12);
    chk("R6 irq race", {7'b0, ms_irq}, 8'h01);
    rd_reg(1'b1, d);
    peek(1'b1, d); chk("R3 dsr clear", d, 8'h10);
  endtask

  task automatic t_loop();
    logic [7:0] d;
    wr_ctl(8'h1B);
    chk("R9 pins", {4'b0, out2_o, out1_o, rts_o, dtr_o}, 8'h08);
    peek(1'b1, d); chk("R8 map a", d, 8'hB0);
    wr_ctl(8'h14);
    peek(1'b0, d); chk("R2 loop ctl", d, 8'h14);
    peek(1'b1, d); chk("R8 map b", d, 8'h40);
    chk("R10 irq looped", {7'b0, ms_irq}, 8'h00);
    dcd_i = 1'b1; ri_i = 1'b1;
    tick(4);
    peek(1'b1, d); chk("R10 ext ignored", d, 8'h40);
    ri_i = 1'b0;
    tick(4);
    peek(1'b1, d); chk("R10 ring ignored", d, 8'h40);
    chk("R10 irq", {7'b0, ms_irq}, 8'h00);
    wr_ctl(8'h08);
    peek(1'b1, d); chk("R10 exit", d, 8'h90);
    chk("R10 irq exit", {7'b0, ms_irq}, 8'h00);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_ctl();
    t_cts();
    t_ring();
    t_multi();
    t_race();
    t_loop();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule